// File: doc/BRIEF.md
# Transfer Unit Size Search Engine

This block picks the transfer-unit size and the whole number of valid symbols per unit that a display link framer needs for one video mode. It is given the pixel clock in kHz, the colour depth in bits per component, a flag for 4:2:2 chroma sampling, the number of active lanes and the per-lane link rate in MHz. It then walks even candidate sizes upwards. For each candidate it works out the valid-symbol figure in thousandths and keeps the first one whose integer part and fraction are both acceptable.

All divisions run on one shared, multi-cycle restoring divider. Each candidate therefore costs a fixed, bounded number of cycles, and the block needs no wide combinational dividers. When a candidate is accepted, the block packs the framer word and works out a FIFO fill setting from the accepted count. When every candidate up to the upper size limit has been rejected, it reports an error instead.

The host pulses a start strobe. It then watches the busy output and waits for the done level. The results stay frozen until the next start.

Top module: `tu_size_search`

## Requirements
- R1: After reset, busy, done and error are 0, and the framer word and the FIFO fill are 0.
- R2: Bits per pixel are twice the colour depth when the 4:2:2 flag is 1, and three times the colour depth when it is 0.
- R3: Candidate sizes are 34, 36, 38 and so on, rising by 2 and never going above 64. The result is the smallest size that is accepted.
- R4: For a candidate of size S, V = floor(S × pclk_kHz × bpp / (lanes × rate_MHz × 8)). The count is floor(V / 1000) and the fraction is V mod 1000.
- R5: A candidate whose count is 0 or 1 is rejected.
- R6: A candidate whose count plus 4 exceeds its size is rejected.
- R7: A candidate is accepted only if its fraction lies between 100 and 850, both ends included.
- R8: If no size up to 64 is accepted, done and error are both 1, and the framer word and the FIFO fill are 0.
- R9: On success, framer_o bit 15 is 1, bits 14:8 hold the size and bits 7:0 hold the count.
- R10: On success, fifo_o = floor(8(c+1)/bpp) − floor((floor(pclk_kHz(c+1)/1000) + rate)/(lanes × rate)) + 2, taken modulo 2^16, where c is the count.
- R11: A start pulse while idle raises busy in the next cycle, clears done and captures all operand inputs. Once done, all outputs hold until the next start. Changes to the operands, and start pulses, while busy have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| pclk_khz_i | input | 20 | Pixel clock in kHz |
| depth_i | input | 5 | Colour depth in bits per component |
| half_chroma_i | input | 1 | 1 selects 4:2:2 sampling |
| lanes_i | input | 3 | Active lane count (non-zero) |
| rate_mhz_i | input | 10 | Per-lane link rate in MHz (non-zero) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Result valid; held until next start |
| error_o | output | 1 | No candidate accepted |
| framer_o | output | 16 | Packed framer word |
| fifo_o | output | 16 | FIFO fill setting, two's complement |

## Verification
Most internal faults show up only once the search ends, because the size, count and fraction registers are never visible on their own. A wrong step, a slipped bound or a bad divider bit leaves a framer word with the wrong size or count field, or a wrong FIFO value, at the cycle done rises. A few hundred to about two thousand cycles after start, the packed size field, the count field and the FIFO value can each be compared with an independent arithmetic model. A handshake fault shows up sooner: the cycle after start, busy fails to rise, or the held outputs move while done is high.

// File: rtl/tu_pkg.sv
package tu_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_STEP  = 4'd1,
        ST_DSYM  = 4'd2,
        ST_DFRAC = 4'd3,
        ST_JUDGE = 4'd4,
        ST_DF1   = 4'd5,
        ST_DF2   = 4'd6,
        ST_DF3   = 4'd7
    } tu_state_e;

endpackage

// File: rtl/tu_restoring_div.sv
module tu_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     quo;
        logic [W-1:0]     rem;
        logic [W-1:0]     dvs;
    } div_regs_t;

    div_regs_t q, d;
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem, q.quo[W-1]};
        diff    = shifted - {1'b0, q.dvs};
        if (start_i) begin
            d.run = 1'b1;
            d.cnt = CNT_W'(W);
            d.quo = dividend_i;
            d.rem = '0;
            d.dvs = divisor_i;
        end else if (q.run) begin
            if (!diff[W]) begin
                d.rem = diff[W-1:0];
            end else begin
                d.rem = shifted[W-1:0];
            end
            d.quo = {q.quo[W-2:0], ~diff[W]};
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quo_o  = q.quo;
    assign rem_o  = q.rem;
endmodule

// File: rtl/tu_candidate_judge.sv
module tu_candidate_judge #(
    parameter int SIZE_W  = 8,
    parameter int DIV_W   = 32,
    parameter int MIN_GAP = 4,
    parameter int FRAC_LO = 100,
    parameter int FRAC_HI = 850
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [DIV_W-1:0]  cnt_i,
    input  logic [DIV_W-1:0]  frac_i,
    output logic              ok_o
);
    logic cnt_big, gap_ok, frac_ok;

    always_comb begin
        cnt_big = cnt_i > DIV_W'(1);
        gap_ok  = (cnt_i + DIV_W'(MIN_GAP)) <= DIV_W'(size_i);
        frac_ok = (frac_i >= DIV_W'(FRAC_LO)) && (frac_i <= DIV_W'(FRAC_HI));
        ok_o    = cnt_big && gap_ok && frac_ok;
    end
endmodule

// File: rtl/tu_size_search.sv
module tu_size_search
    import tu_pkg::*;
#(
    parameter int PCLK_W   = 20,
    parameter int RATE_W   = 10,
    parameter int LANE_W   = 3,
    parameter int DEPTH_W  = 5,
    parameter int DIV_W    = 32,
    parameter int SIZE_W   = 8,
    parameter int TU_BASE  = 32,
    parameter int TU_STEP  = 2,
    parameter int TU_MAX   = 64,
    parameter int MIN_GAP  = 4,
    parameter int FRAC_LO  = 100,
    parameter int FRAC_HI  = 850,
    parameter int FRAC_DIV = 1000,
    parameter int FIFO_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [PCLK_W-1:0]  pclk_khz_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic               half_chroma_i,
    input  logic [LANE_W-1:0]  lanes_i,
    input  logic [RATE_W-1:0]  rate_mhz_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o,
    output logic [15:0]        framer_o,
    output logic [FIFO_W-1:0]  fifo_o
);
    localparam int BPP_W      = DEPTH_W + 2;
    localparam int CNT_FLD_W  = 8;
    localparam int SIZE_FLD_W = 7;
    localparam int FRAMER_W   = 1 + SIZE_FLD_W + CNT_FLD_W;
    localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO   = DIV_W'(2);
    localparam logic [DIV_W-1:0] K_DIV = DIV_W'(FRAC_DIV);

    typedef struct packed {
        tu_state_e            state;
        logic                 wait_div;
        logic [PCLK_W-1:0]    pclk;
        logic [BPP_W-1:0]     bpp;
        logic [LANE_W-1:0]    lanes;
        logic [RATE_W-1:0]    rate;
        logic [SIZE_W-1:0]    size;
        logic [DIV_W-1:0]     cnt;
        logic [DIV_W-1:0]     frac;
        logic [DIV_W-1:0]     tmp;
        logic                 done;
        logic                 err;
        logic [FRAMER_W-1:0]  framer;
        logic [FIFO_W-1:0]    fifo;
    } tu_regs_t;

    tu_regs_t q, d;

    logic             div_start;
    logic [DIV_W-1:0] div_dvd, div_dvs, div_quo, div_rem;
    logic             div_done;
    logic             cand_ok;
    logic [SIZE_W-1:0] size_next;

    // Operand selection for the single shared divider
    always_comb begin
        div_dvd = '0;
        div_dvs = ONE;
        unique case (q.state)
            ST_DSYM: begin
                div_dvd = DIV_W'(q.size) * DIV_W'(q.pclk) * DIV_W'(q.bpp);
                div_dvs = (DIV_W'(q.lanes) * DIV_W'(q.rate)) << 3;
            end
            ST_DFRAC: begin
                div_dvd = q.tmp;
                div_dvs = K_DIV;
            end
            ST_DF1: begin
                div_dvd = DIV_W'(q.pclk) * (q.cnt + ONE);
                div_dvs = K_DIV;
            end
            ST_DF2: begin
                div_dvd = q.tmp + DIV_W'(q.rate);
                div_dvs = DIV_W'(q.lanes) * DIV_W'(q.rate);
            end
            ST_DF3: begin
                div_dvd = (q.cnt + ONE) << 3;
                div_dvs = DIV_W'(q.bpp);
            end
            default: ;
        endcase
    end

    tu_restoring_div #(.W(DIV_W)) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dvd),
        .divisor_i  (div_dvs),
        .done_o     (div_done),
        .quo_o      (div_quo),
        .rem_o      (div_rem)
    );

    tu_candidate_judge #(
        .SIZE_W  (SIZE_W),
        .DIV_W   (DIV_W),
        .MIN_GAP (MIN_GAP),
        .FRAC_LO (FRAC_LO),
        .FRAC_HI (FRAC_HI)
    ) i_judge (
        .size_i (q.size),
        .cnt_i  (q.cnt),
        .frac_i (q.frac),
        .ok_o   (cand_ok)
    );

    assign size_next = q.size + SIZE_W'(TU_STEP);

    always_comb begin
        d         = q;
        div_start = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.pclk   = pclk_khz_i;
                    d.lanes  = lanes_i;
                    d.rate   = rate_mhz_i;
                    d.bpp    = half_chroma_i ? BPP_W'({depth_i, 1'b0})
                                             : BPP_W'({depth_i, 1'b0}) + BPP_W'(depth_i);
                    d.size   = SIZE_W'(TU_BASE);
                    d.done   = 1'b0;
                    d.err    = 1'b0;
                    d.framer = '0;
                    d.fifo   = '0;
                    d.state  = ST_STEP;
                end
            end
            ST_STEP: begin
                d.size = size_next;
                if (size_next > SIZE_W'(TU_MAX)) begin
                    d.err   = 1'b1;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.state = ST_DSYM;
                end
            end
            ST_JUDGE: begin
                d.state = cand_ok ? ST_DF1 : ST_STEP;
            end
            default: begin
                // Every remaining state runs one division
                if (!q.wait_div) begin
                    div_start  = 1'b1;
                    d.wait_div = 1'b1;
                end else if (div_done) begin
                    d.wait_div = 1'b0;
                    unique case (q.state)
                        ST_DSYM: begin
                            d.tmp   = div_quo;
                            d.state = ST_DFRAC;
                        end
                        ST_DFRAC: begin
                            d.cnt   = div_quo;
                            d.frac  = div_rem;
                            d.state = ST_JUDGE;
                        end
                        ST_DF1: begin
                            d.tmp   = div_quo;
                            d.state = ST_DF2;
                        end
                        ST_DF2: begin
                            d.tmp   = div_quo;
                            d.state = ST_DF3;
                        end
                        default: begin
                            d.fifo   = FIFO_W'(div_quo - q.tmp + TWO);
                            d.framer = {1'b1, q.size[SIZE_FLD_W-1:0], q.cnt[CNT_FLD_W-1:0]};
                            d.done   = 1'b1;
                            d.state  = ST_IDLE;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o   = (q.state != ST_IDLE);
    assign done_o   = q.done;
    assign error_o  = q.err;
    assign framer_o = q.framer;
    assign fifo_o   = q.fifo;
endmodule

// File: rtl/tu_size_search_chk.sv
module tu_size_search_chk #(
    parameter int FIFO_W  = 16,
    parameter int TU_BASE = 32,
    parameter int TU_MAX  = 64,
    parameter int MIN_GAP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              error_o,
    input logic [15:0]       framer_o,
    input logic [FIFO_W-1:0] fifo_o
);
    p_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !done_o));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(framer_o) && $stable(fifo_o) && $stable(error_o)));

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (done_o && framer_o == 16'd0 && fifo_o == '0));

    p_tag_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> framer_o[15]);

    p_size_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> (!framer_o[8] && framer_o[14:8] > 7'(TU_BASE)
                                  && framer_o[14:8] <= 7'(TU_MAX)));

    p_count_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> (framer_o[7:0] > 8'd1));

    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> ({1'b0, framer_o[7:0]} + 9'(MIN_GAP) <= {2'b00, framer_o[14:8]}));
endmodule

bind tu_size_search tu_size_search_chk #(
    .FIFO_W  (FIFO_W),
    .TU_BASE (TU_BASE),
    .TU_MAX  (TU_MAX),
    .MIN_GAP (MIN_GAP)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .error_o  (error_o),
    .framer_o (framer_o),
    .fifo_o   (fifo_o)
);

// File: tb/test_tu_size_search.sv
module test_tu_size_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] pclk = '0;
    logic [4:0]  depth = '0;
    logic        half = 1'b0;
    logic [2:0]  lanes = 3'd1;
    logic [9:0]  rate = 10'd1;
    logic        busy, done, err;
    logic [15:0] framer, fifo;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tu_size_search i_tu_size_search (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .pclk_khz_i    (pclk),
        .depth_i       (depth),
        .half_chroma_i (half),
        .lanes_i       (lanes),
        .rate_mhz_i    (rate),
        .busy_o        (busy),
        .done_o        (done),
        .error_o       (err),
        .framer_o      (framer),
        .fifo_o        (fifo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent arithmetic model of the requirements
    function automatic void model(input int pc, input int dp, input bit h, input int ln, input int rt,
                                  output bit e, output int fr, output int ff);
        int bpp = h ? 2 * dp : 3 * dp;
        e = 1'b1; fr = 0; ff = 0;
        for (int s = 34; s <= 64; s += 2) begin
            longint v = (longint'(s) * pc * bpp) / (longint'(ln) * rt * 8);
            longint c = v / 1000;
            longint f = v % 1000;
            if (c <= 1 || c + 4 > s || f > 850 || f < 100) continue;
            begin
                longint t1 = (longint'(pc) * (c + 1)) / 1000;
                longint t2 = (t1 + rt) / (longint'(ln) * rt);
                longint t3 = (8 * (c + 1)) / bpp;
                e  = 1'b0;
                fr = 32'h8000 | (s << 8) | int'(c);
                ff = int'((t3 - t2 + 2) & 64'hFFFF);
            end
            break;
        end
    endfunction

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk({req, " timeout"}, 32'd0, 32'd1);
    endtask

    task automatic run(input int pc, input int dp, input bit h, input int ln, input int rt,
                       input string tag, input bit disturb);
        bit e; int fr; int ff;
        model(pc, dp, h, ln, rt, e, fr, ff);
        @(negedge clk);
        pclk = 20'(pc); depth = 5'(dp); half = h; lanes = 3'(ln); rate = 10'(rt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R11 busy after start"}, 32'(busy), 32'd1);
        if (disturb) begin
            repeat (15) @(negedge clk);
            // R11: operand changes and a second start while busy must not matter
            pclk = 20'd1000; depth = 5'd16; lanes = 3'd1; rate = 10'd162;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(tag);
        chk({tag, " R8 error flag"}, 32'(err), 32'(e));
        chk({tag, " R4 R9 framer word"}, 32'(framer), 32'(fr));
        chk({tag, " R10 fifo fill"}, 32'(fifo), 32'(ff));
        repeat (4) @(negedge clk);
        chk({tag, " R11 held framer"}, 32'(framer), 32'(fr));
        chk({tag, " R11 held done"}, 32'(done), 32'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int dl[5] = '{6, 8, 10, 12, 16};
        int rl[4] = '{162, 270, 540, 810};
        int ll[3] = '{1, 2, 4};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 error", 32'(err), 32'd0);
        chk("R1 framer", 32'(framer), 32'd0);
        chk("R1 fifo", 32'(fifo), 32'd0);

        // R3 R7: size 36 gives fraction exactly 850, accepted at upper band edge
        run(148500, 8, 1'b0, 4, 270, "R3 R7 edge", 1'b0);
        chk("R7 R3 framer A40E", 32'(framer), 32'h0000A40E);
        // R5 R8: count stays below 2 for every size
        run(1000, 8, 1'b0, 4, 540, "R5 R8 low", 1'b0);
        chk("R8 error set", 32'(err), 32'd1);
        // R6 R8: count always exceeds size minus 4
        run(600000, 16, 1'b0, 1, 162, "R6 R8 high", 1'b0);
        chk("R6 error set", 32'(err), 32'd1);
        // R2: 4:2:2 sampling uses twice the depth
        run(297000, 10, 1'b1, 4, 540, "R2 half chroma", 1'b0);
        run(74250, 12, 1'b1, 2, 270, "R2 half chroma b", 1'b0);
        // R11: disturbance while busy
        run(148500, 8, 1'b0, 4, 270, "R11 disturb", 1'b1);

        // Random mix (R3 R4 R5 R6 R7 R9 R10)
        for (int i = 0; i < 24; i++) begin
            int pc = 25000 + int'($urandom % 575000);
            run(pc, dl[$urandom % 5], 1'($urandom % 2), ll[$urandom % 3], rl[$urandom % 4],
                "rand", 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule